// File: doc/BRIEF.md
# Saturating Integer Element Clamp

This block takes one integer element result, already computed at the wider of the source and destination element widths, and narrows it to a destination element width of 8, 16, 32 or 64 bits. It clamps the value to the range of that width instead of letting it wrap. A mode input selects the range. Unsigned mode clamps to 0 up to 2^w-1. Signed mode clamps to the two's-complement minimum and maximum of w bits.

When the record-flag input is set, the block also reports one overflow flag for this element. The flag says only whether this element was clamped. No sticky summary overflow is read or accumulated. Asking for an overflow-enabled form together with saturation is an illegal combination, and the block flags it. The value is one clock behind the inputs, held in an output register stage that a parameter can remove.

Top module: `sat_clamp_unit`

## Requirements
- R1: In unsigned mode (`signed_i`=0) the output is the input clamped to 0..2^w-1. Here w = 8 << `dw_sel_i`: code 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Bits of `val_o` at and above w are 0.
- R2: In signed mode (`signed_i`=1) the output is the input clamped to -2^(w-1)..2^(w-1)-1. It is given as a w-bit two's-complement pattern in the low bits of `val_o`, and the bits above w are 0.
- R3: In unsigned mode a negative input (sign bit of `res_i` set) gives `val_o`=0, and it counts as a clamp.
- R4: With `rc_i`=1, `ovf_o` is 1 exactly when the input lay outside the selected range, and 0 otherwise.
- R5: With `rc_i`=0, `ovf_o` is 0 whatever the input is.
- R6: `illegal_o` equals the `oe_i` that went with the element.
- R7: An input inside the selected range passes unchanged. `val_o` equals its low w bits.
- R8: Outputs appear one clock after the inputs, and `out_valid_o` follows `in_valid_i`. While `out_valid_o` is 0, and in the cycle after a synchronous reset, `val_o`, `ovf_o` and `illegal_o` are all 0.
- R9: `oe_i` has no effect on `val_o` or `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Element present |
| res_i | input | RES_W (72) | Wide two's-complement result |
| signed_i | input | 1 | 1 = signed clamp, 0 = unsigned |
| dw_sel_i | input | SEL_W (2) | Destination width code, 8 << code bits |
| rc_i | input | 1 | Record overflow flag |
| oe_i | input | 1 | Overflow-enable requested (illegal with saturation) |
| out_valid_o | output | 1 | Result valid |
| val_o | output | DST_W (64) | Clamped value, zero-extended |
| ovf_o | output | 1 | Per-element saturation flag |
| illegal_o | output | 1 | Illegal-instruction indication |

## Verification
The hardest cases are inputs one step past a limit. Examples are 2^w against 2^w-1, -2^(w-1)-1, and values just above 2^64 at the widest setting. Uniform random values almost never land on these. The stimulus therefore draws from shaped classes for each width: values shifted to fit the width, values shifted one bit wider, explicit limit values with offsets of -1, 0 and +1, and the full 72-bit range. It crosses each class with both modes and both flag settings.

// File: rtl/sat_clamp_pkg.sv
package sat_clamp_pkg;

  typedef struct packed {
    logic valid;
    logic ovf;
    logic illegal;
  } sat_flags_t;

  // Bit width of lane option idx given the narrowest option.
  function automatic int lane_width(input int min_w, input int idx);
    return min_w << idx;
  endfunction

endpackage

// File: rtl/sat_limits.sv
module sat_limits #(
  parameter int RES_W = 72,
  parameter int MIN_W = 8,
  parameter int NUM_W = 4,
  parameter int SEL_W = 2,
  parameter int DST_W = 64
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             signed_i,
  output logic [RES_W-1:0] hi_o,
  output logic [RES_W-1:0] lo_o,
  output logic [DST_W-1:0] mask_o
);
  import sat_clamp_pkg::*;

  logic [RES_W-1:0] u_hi [NUM_W];
  logic [RES_W-1:0] s_hi [NUM_W];
  logic [RES_W-1:0] s_lo [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_lane
    localparam int W = lane_width(MIN_W, g);
    assign u_hi[g] = {{(RES_W - W){1'b0}}, {W{1'b1}}};
    assign s_hi[g] = {{(RES_W - W + 1){1'b0}}, {(W - 1){1'b1}}};
    assign s_lo[g] = {{(RES_W - W + 1){1'b1}}, {(W - 1){1'b0}}};
  end

  always_comb begin
    if (signed_i) begin
      hi_o = s_hi[sel_i];
      lo_o = s_lo[sel_i];
    end else begin
      hi_o = u_hi[sel_i];
      lo_o = '0;
    end
    mask_o = u_hi[sel_i][DST_W-1:0];
  end

endmodule

// File: rtl/sat_core.sv
module sat_core #(
  parameter int RES_W = 72,
  parameter int DST_W = 64
) (
  input  logic [RES_W-1:0] res_i,
  input  logic [RES_W-1:0] hi_i,
  input  logic [RES_W-1:0] lo_i,
  input  logic [DST_W-1:0] mask_i,
  output logic [DST_W-1:0] val_o,
  output logic             hit_o
);
  logic             above, below;
  logic [RES_W-1:0] picked;

  always_comb begin
    above  = $signed(res_i) > $signed(hi_i);
    below  = $signed(res_i) < $signed(lo_i);
    if (above)      picked = hi_i;
    else if (below) picked = lo_i;
    else            picked = res_i;
    val_o  = picked[DST_W-1:0] & mask_i;
    hit_o  = above | below;
  end

endmodule

// File: rtl/sat_stage.sv
module sat_stage #(
  parameter int DST_W   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  sat_clamp_pkg::sat_flags_t flags_i,
  input  logic [DST_W-1:0]          val_i,
  output sat_clamp_pkg::sat_flags_t flags_o,
  output logic [DST_W-1:0]          val_o
);
  import sat_clamp_pkg::*;

  sat_flags_t       gated_flags;
  logic [DST_W-1:0] gated_val;

  always_comb begin
    gated_flags.valid   = flags_i.valid;
    gated_flags.ovf     = flags_i.valid & flags_i.ovf;
    gated_flags.illegal = flags_i.valid & flags_i.illegal;
    gated_val           = flags_i.valid ? val_i : '0;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_o <= '0;
        val_o   <= '0;
      end else begin
        flags_o <= gated_flags;
        val_o   <= gated_val;
      end
    end
  end else begin : g_comb
    assign flags_o = gated_flags;
    assign val_o   = gated_val;
  end

endmodule

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit #(
  parameter int RES_W   = 72,
  parameter int MIN_W   = 8,
  parameter int NUM_W   = 4,
  parameter bit OUT_REG = 1'b1,
  localparam int SEL_W  = $clog2(NUM_W),
  localparam int DST_W  = MIN_W << (NUM_W - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             signed_i,
  input  logic [SEL_W-1:0] dw_sel_i,
  input  logic             rc_i,
  input  logic             oe_i,
  output logic             out_valid_o,
  output logic [DST_W-1:0] val_o,
  output logic             ovf_o,
  output logic             illegal_o
);
  import sat_clamp_pkg::*;

  logic [RES_W-1:0] hi, lo;
  logic [DST_W-1:0] mask, clamped;
  logic             hit;
  sat_flags_t       flags_c, flags_q;

  sat_limits #(
    .RES_W(RES_W), .MIN_W(MIN_W), .NUM_W(NUM_W), .SEL_W(SEL_W), .DST_W(DST_W)
  ) u_limits (
    .sel_i(dw_sel_i), .signed_i(signed_i),
    .hi_o(hi), .lo_o(lo), .mask_o(mask)
  );

  sat_core #(.RES_W(RES_W), .DST_W(DST_W)) u_core (
    .res_i(res_i), .hi_i(hi), .lo_i(lo), .mask_i(mask),
    .val_o(clamped), .hit_o(hit)
  );

  always_comb begin
    flags_c.valid   = in_valid_i;
    flags_c.ovf     = rc_i & hit;
    flags_c.illegal = oe_i;
  end

  sat_stage #(.DST_W(DST_W), .OUT_REG(OUT_REG)) u_stage (
    .clk(clk), .rst(rst),
    .flags_i(flags_c), .val_i(clamped),
    .flags_o(flags_q), .val_o(val_o)
  );

  assign out_valid_o = flags_q.valid;
  assign ovf_o       = flags_q.ovf;
  assign illegal_o   = flags_q.illegal;

endmodule

// File: rtl/sat_clamp_checker.sv
module sat_clamp_checker #(
  parameter int RES_W   = 72,
  parameter int MIN_W   = 8,
  parameter int NUM_W   = 4,
  parameter bit OUT_REG = 1'b1,
  parameter int SEL_W   = 2,
  parameter int DST_W   = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid_i,
  input logic [RES_W-1:0] res_i,
  input logic             signed_i,
  input logic [SEL_W-1:0] dw_sel_i,
  input logic             rc_i,
  input logic             oe_i,
  input logic             out_valid_o,
  input logic [DST_W-1:0] val_o,
  input logic             ovf_o,
  input logic             illegal_o
);
  function automatic logic [DST_W-1:0] width_mask(input logic [SEL_W-1:0] s);
    logic [DST_W-1:0] m;
    for (int b = 0; b < DST_W; b++) m[b] = (b < (MIN_W << s));
    return m;
  endfunction

  if (OUT_REG) begin : g_props
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> out_valid_o == $past(in_valid_i));

    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !out_valid_o |-> (val_o == '0 && !ovf_o && !illegal_o));

    assert_illegal_tracks_oe_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !$past(rst)) |-> illegal_o == $past(oe_i));

    assert_no_flag_without_rc_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !$past(rst) && !$past(rc_i)) |-> !ovf_o);

    assert_upper_bits_clear_R1: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !$past(rst)) |-> (val_o & ~width_mask($past(dw_sel_i))) == '0);

    assert_unsigned_neg_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !$past(rst) && !$past(signed_i) && $past(res_i[RES_W-1]))
        |-> val_o == '0);

    assert_pass_through_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !$past(rst) && $past(rc_i) && !ovf_o)
        |-> val_o == ($past(res_i[DST_W-1:0]) & width_mask($past(dw_sel_i))));
  end

endmodule

bind sat_clamp_unit sat_clamp_checker #(
  .RES_W(RES_W), .MIN_W(MIN_W), .NUM_W(NUM_W), .OUT_REG(OUT_REG),
  .SEL_W(SEL_W), .DST_W(DST_W)
) u_chk (.*);

// File: tb/sat_clamp_unit_bench.sv
`timescale 1ns/1ps
module sat_clamp_unit_bench;
  localparam int RES_W = 72;
  localparam int DST_W = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid_i = 1'b0;
  logic [RES_W-1:0] res_i = '0;
  logic             signed_i = 1'b0;
  logic [1:0]       dw_sel_i = '0;
  logic             rc_i = 1'b0;
  logic             oe_i = 1'b0;
  logic             out_valid_o;
  logic [DST_W-1:0] val_o;
  logic             ovf_o;
  logic             illegal_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sat_clamp_unit u_sat_clamp_unit (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .res_i(res_i),
    .signed_i(signed_i), .dw_sel_i(dw_sel_i), .rc_i(rc_i), .oe_i(oe_i),
    .out_valid_o(out_valid_o), .val_o(val_o), .ovf_o(ovf_o), .illegal_o(illegal_o)
  );

  // expected outputs for the element driven one cycle earlier
  logic             e_valid, e_ovf, e_ill;
  logic [DST_W-1:0] e_val;
  string            e_tag;

  task automatic check(input string req, input logic [DST_W-1:0] act,
                       input logic [DST_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic predict(input logic v, input logic [RES_W-1:0] r, input bit s,
                         input int code, input bit rc, input bit oe);
    int w;
    logic signed [RES_W+1:0] x, top, bot, one, c;
    bit clipped;
    w   = 8 << code;
    one = 1;
    x   = $signed(r);
    if (s) begin
      top = (one <<< (w - 1)) - 1;
      bot = -top - 1;
    end else begin
      top = (one <<< w) - 1;
      bot = 0;
    end
    clipped = 0;
    if (x > top)      begin c = top; clipped = 1; end
    else if (x < bot) begin c = bot; clipped = 1; end
    else              c = x;
    e_valid = v;
    e_val   = v ? (c[DST_W-1:0] & ((w == 64) ? {DST_W{1'b1}} : ((64'd1 << w) - 1))) : '0;
    e_ovf   = v & rc & clipped;
    e_ill   = v & oe;
    if (!clipped)           e_tag = "R7";
    else if (!s && x < 0)   e_tag = "R3";
    else if (s)             e_tag = "R2";
    else                    e_tag = "R1";
  endtask

  function automatic logic [RES_W-1:0] shaped(input int code, input int k);
    int w;
    logic [RES_W-1:0] raw, base;
    int off;
    w   = 8 << code;
    raw = {$urandom, $urandom, $urandom};
    off = int'($urandom % 3) - 1;
    case (k)
      0: return $signed(raw) >>> (RES_W - w);
      1: return $signed(raw) >>> (RES_W - w - 1);
      2: return raw >> (RES_W - w);
      3: begin
        base = (RES_W'(1) << (w - (($urandom % 2) ? 1 : 0)));
        if ($urandom % 2) base = -base;
        return base + RES_W'(off);
      end
      default: return raw;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [RES_W-1:0] r, input bit s,
                       input int code, input bit rc, input bit oe);
    in_valid_i = v; res_i = r; signed_i = s; dw_sel_i = code[1:0];
    rc_i = rc; oe_i = oe;
    predict(v, r, s, code, rc, oe);
  endtask

  task automatic compare_all();
    check("R8 valid", {63'd0, out_valid_o}, {63'd0, e_valid});
    check({e_tag, " value"}, val_o, e_val);
    check(rc_i ? "R4 flag" : "R4/R5 flag", {63'd0, ovf_o}, {63'd0, e_ovf});
    check("R6 illegal", {63'd0, illegal_o}, {63'd0, e_ill});
  endtask

  initial begin
    // reset with busy inputs: outputs must stay clear (R8)
    in_valid_i = 1; res_i = '1; rc_i = 1; oe_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset valid", {63'd0, out_valid_o}, 64'd0);
    check("R8 reset value", val_o, 64'd0);
    check("R8 reset flags", {62'd0, ovf_o, illegal_o}, 64'd0);
    rst = 0;
    drive(0, '0, 0, 0, 0, 0);

    // directed corners
    begin
      logic [RES_W-1:0] dv [10];
      int dc [10];
      bit ds [10];
      dv[0] = 72'd256;              dc[0] = 0; ds[0] = 0; // R1 just above 8-bit max
      dv[1] = 72'd255;              dc[1] = 0; ds[1] = 0; // R7 at max
      dv[2] = -72'sd1;              dc[2] = 1; ds[2] = 0; // R3
      dv[3] = 72'd128;              dc[3] = 0; ds[3] = 1; // R2 above signed max
      dv[4] = -72'sd129;            dc[4] = 0; ds[4] = 1; // R2 below signed min
      dv[5] = -72'sd128;            dc[5] = 0; ds[5] = 1; // R7 at signed min
      dv[6] = 72'h1_0000_0000_0000_0000; dc[6] = 3; ds[6] = 0; // R1 64-bit
      dv[7] = 72'h0_8000_0000_0000_0000; dc[7] = 3; ds[7] = 1; // R2 64-bit
      dv[8] = 72'hFF_7FFF_FFFF_FFFF_FFFF; dc[8] = 3; ds[8] = 1; // R2 64-bit min-1
      dv[9] = 72'd70000;            dc[9] = 2; ds[9] = 1; // R7 32-bit
      for (int i = 0; i < 10; i++) begin
        for (int f = 0; f < 4; f++) begin
          @(negedge clk);
          compare_all();
          drive(1, dv[i], ds[i], dc[i], f[0], f[1]); // R9 oe toggled
        end
      end
    end

    // shaped random sweep
    for (int n = 0; n < 4000; n++) begin
      int code;
      @(negedge clk);
      compare_all();
      code = int'($urandom % 4);
      drive(($urandom % 8) != 0, shaped(code, int'($urandom % 5)),
            $urandom % 2, code, $urandom % 2, ($urandom % 4) == 0);
    end
    @(negedge clk);
    compare_all();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule